// File: doc/BRIEF.md
# Inset Window, Wipe and Border Generator

This block produces the timing of a picture-in-picture inset on the main screen. It keeps a pixel counter and a line counter. Both run from the main screen's active-low sync inputs. Each screen position is compared against a rectangle built from an 8-bit horizontal and vertical start position and a fixed inset size. The result selects, pixel by pixel, whether the main or the sub picture is shown.

Each of the four edges of the rectangle can be masked by a 6-bit range. This happens either as a wipe, where the edge and its border move inward, or as a display-area limit, where the strip is blanked but the border stays on the full rectangle. A border two pixels wide and one line high is drawn just outside the rectangle. The border always appears as a pin pulse. When enabled, it is also given as 4-bit luminance and two colour-difference values for overlay.

All settings are copied into a shadow at the main vertical sync. A field is therefore drawn with one consistent set of values.

Top module: `inset_window_gen`

## Requirements
- R1: While reset is held, and afterwards until the first vertical sync falling edge, every output is 0.
- R2: The pixel counter is 0 in the cycle after the clock edge that first sees `hsync_n` low, and it counts up by one per clock. The line counter is 0 after the edge that first sees `vsync_n` low, and it counts up by one on every later `hsync_n` falling edge.
- R3: With masking off, `inset_active` is 1 exactly when `hpos <= pixel < hpos+INSET_W` and `vpos <= line < vpos+INSET_H`.
- R4: When the latched `disp_on` is 0, every output is 0.
- R5: Setting inputs that change between vertical syncs have no effect until the next `vsync_n` falling edge.
- R6: In wipe mode (`mask_en`=1, `wipe_mode`=1), each enabled edge moves inward: left and right by `hrange`, top and bottom by `vrange`. The border follows the moved edges. `edge_en` bit 3 is top, bit 2 bottom, bit 1 left, bit 0 right.
- R7: In area mode (`mask_en`=1, `wipe_mode`=0), each enabled edge blanks a strip of the same width inside the rectangle. The border stays around the full rectangle.
- R8: With `mask_en`=0, `edge_en`, `hrange`, `vrange` and `wipe_mode` have no effect.
- R9: `border_pin` is 1 on the pixels within 2 pixels left/right and 1 line above/below the border rectangle but outside it. It is never 1 together with `inset_active`.
- R10: `border_ovl` is 1 where `border_pin` is 1 and `color_en` is set, and the colour outputs then carry the latched values. Otherwise the colour outputs are 0.
- R11: If the masked left and right ranges together reach `INSET_W`, or the top and bottom ranges reach `INSET_H`, `inset_active` stays 0. In wipe mode the border is also suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | Main horizontal sync, active low |
| vsync_n | input | 1 | Main vertical sync, active low |
| hpos | input | 8 | Inset horizontal start pixel |
| vpos | input | 8 | Inset vertical start line |
| hrange | input | 6 | Horizontal mask range |
| vrange | input | 6 | Vertical mask range |
| edge_en | input | 4 | Edge enables: 3 top, 2 bottom, 1 left, 0 right |
| wipe_mode | input | 1 | 1 wipe, 0 display-area limit |
| mask_en | input | 1 | Enables edge masking |
| disp_on | input | 1 | Inset display on |
| color_en | input | 1 | Border colour overlay enable |
| col_y | input | 4 | Border luminance |
| col_ry | input | 4 | Border R-Y value |
| col_by | input | 4 | Border B-Y value |
| inset_active | output | 1 | Selects the sub picture |
| border_pin | output | 1 | Border region pulse |
| border_ovl | output | 1 | Border colour overlay valid |
| ovl_y | output | 4 | Overlay luminance |
| ovl_ry | output | 4 | Overlay R-Y |
| ovl_by | output | 4 | Overlay B-Y |

## Verification
Every pixel of whole fields is compared with an arithmetic model. Each field uses a different setting: a plain rectangle, masking disabled with edge bits set, wipe on two edge pairs, area mode on all edges, a collapsed wipe, display off, and a rectangle at the origin. Wipe and area fields differ only in where the border lies, so a swapped mode bit shows up. The origin field shows whether negative border coordinates wrap. In every field the setting inputs are inverted after the first line, so any leak past the shadow changes the picture.

// File: rtl/inset_pkg.sv
package inset_pkg;

    localparam int COORD_W = 12;

    localparam int EDGE_TOP    = 3;
    localparam int EDGE_BOTTOM = 2;
    localparam int EDGE_LEFT   = 1;
    localparam int EDGE_RIGHT  = 0;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        logic [7:0] hpos;
        logic [7:0] vpos;
        logic [5:0] hrange;
        logic [5:0] vrange;
        logic [3:0] edge_en;
        logic       wipe_mode;
        logic       mask_en;
        logic       disp_on;
        logic       color_en;
        logic [3:0] col_y;
        logic [3:0] col_ry;
        logic [3:0] col_by;
    } inset_cfg_t;

    typedef struct packed {
        coord_t left;
        coord_t right;
        coord_t top;
        coord_t bottom;
        logic   valid;
    } rect_t;

    typedef struct packed {
        logic       active;
        logic       pin;
        logic       ovl;
        logic [3:0] y;
        logic [3:0] ry;
        logic [3:0] by;
    } inset_out_t;

    function automatic logic in_span(coord_t v, coord_t lo, coord_t hi);
        return (v >= lo) && (v < hi);
    endfunction

    function automatic coord_t edge_cut(logic mask, logic en, logic [5:0] range_v);
        return (mask && en) ? coord_t'(range_v) : '0;
    endfunction

endpackage

// File: rtl/inset_sync_counter.sv
module inset_sync_counter #(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_n,
    input  logic              vsync_n,
    output logic [PIX_W-1:0]  pix,
    output logic [LINE_W-1:0] line,
    output logic              field_start
);
    logic hs_q, vs_q;
    logic hs_fall;

    assign hs_fall     = hs_q & ~hsync_n;
    assign field_start = vs_q & ~vsync_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b1;
            vs_q <= 1'b1;
        end else begin
            hs_q <= hsync_n;
            vs_q <= vsync_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix <= '0;
        end else if (hs_fall) begin
            pix <= '0;
        end else if (pix != {PIX_W{1'b1}}) begin
            pix <= pix + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= '0;
        end else if (field_start) begin
            line <= '0;
        end else if (hs_fall && (line != {LINE_W{1'b1}})) begin
            line <= line + 1'b1;
        end
    end
endmodule

// File: rtl/inset_cfg_shadow.sv
module inset_cfg_shadow
    import inset_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  inset_cfg_t cfg_in,
    output inset_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/inset_geometry.sv
module inset_geometry
    import inset_pkg::*;
#(
    parameter int INSET_W = 96,
    parameter int INSET_H = 60
) (
    input  logic [7:0] hpos,
    input  logic [7:0] vpos,
    input  logic [5:0] hrange,
    input  logic [5:0] vrange,
    input  logic [3:0] edge_en,
    input  logic       wipe_mode,
    input  logic       mask_en,
    output rect_t      vis_rect,
    output rect_t      frame_rect
);
    localparam coord_t SIZE_H = coord_t'(INSET_W);
    localparam coord_t SIZE_V = coord_t'(INSET_H);

    rect_t  nom;
    coord_t cut_l, cut_r, cut_t, cut_b;
    logic   h_ok, v_ok;

    always_comb begin
        nom.left   = coord_t'(hpos);
        nom.right  = coord_t'(hpos) + SIZE_H;
        nom.top    = coord_t'(vpos);
        nom.bottom = coord_t'(vpos) + SIZE_V;
        nom.valid  = 1'b1;

        cut_l = edge_cut(mask_en, edge_en[EDGE_LEFT],   hrange);
        cut_r = edge_cut(mask_en, edge_en[EDGE_RIGHT],  hrange);
        cut_t = edge_cut(mask_en, edge_en[EDGE_TOP],    vrange);
        cut_b = edge_cut(mask_en, edge_en[EDGE_BOTTOM], vrange);

        h_ok = (cut_l + cut_r) < SIZE_H;
        v_ok = (cut_t + cut_b) < SIZE_V;

        vis_rect.left   = nom.left + cut_l;
        vis_rect.right  = nom.right - cut_r;
        vis_rect.top    = nom.top + cut_t;
        vis_rect.bottom = nom.bottom - cut_b;
        vis_rect.valid  = h_ok && v_ok;

        frame_rect = (mask_en && wipe_mode) ? vis_rect : nom;
    end
endmodule

// File: rtl/inset_classify.sv
module inset_classify
    import inset_pkg::*;
#(
    parameter int PIX_W     = 10,
    parameter int LINE_W    = 10,
    parameter int BORDER_PX = 2,
    parameter int BORDER_LN = 1
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [LINE_W-1:0] line,
    input  rect_t             vis_rect,
    input  rect_t             frame_rect,
    input  logic              disp_on,
    input  logic              color_en,
    input  logic [3:0]        col_y,
    input  logic [3:0]        col_ry,
    input  logic [3:0]        col_by,
    output inset_out_t        res
);
    localparam coord_t BPX = coord_t'(BORDER_PX);
    localparam coord_t BLN = coord_t'(BORDER_LN);

    coord_t x, y;
    logic   in_vis, in_inner, in_outer, on_frame;

    always_comb begin
        x = coord_t'(pix);
        y = coord_t'(line);

        in_vis   = vis_rect.valid
                 && in_span(x, vis_rect.left, vis_rect.right)
                 && in_span(y, vis_rect.top, vis_rect.bottom);
        in_inner = in_span(x, frame_rect.left, frame_rect.right)
                 && in_span(y, frame_rect.top, frame_rect.bottom);
        in_outer = ((x + BPX) >= frame_rect.left) && (x < (frame_rect.right + BPX))
                 && ((y + BLN) >= frame_rect.top) && (y < (frame_rect.bottom + BLN));
        on_frame = frame_rect.valid && in_outer && !in_inner;

        res.active = disp_on && in_vis;
        res.pin    = disp_on && on_frame;
        res.ovl    = disp_on && on_frame && color_en;
        res.y      = res.ovl ? col_y  : 4'd0;
        res.ry     = res.ovl ? col_ry : 4'd0;
        res.by     = res.ovl ? col_by : 4'd0;
    end
endmodule

// File: rtl/inset_window_gen.sv
module inset_window_gen
    import inset_pkg::*;
#(
    parameter int PIX_W     = 10,
    parameter int LINE_W    = 10,
    parameter int INSET_W   = 96,
    parameter int INSET_H   = 60,
    parameter int BORDER_PX = 2,
    parameter int BORDER_LN = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hsync_n,
    input  logic       vsync_n,
    input  logic [7:0] hpos,
    input  logic [7:0] vpos,
    input  logic [5:0] hrange,
    input  logic [5:0] vrange,
    input  logic [3:0] edge_en,
    input  logic       wipe_mode,
    input  logic       mask_en,
    input  logic       disp_on,
    input  logic       color_en,
    input  logic [3:0] col_y,
    input  logic [3:0] col_ry,
    input  logic [3:0] col_by,
    output logic       inset_active,
    output logic       border_pin,
    output logic       border_ovl,
    output logic [3:0] ovl_y,
    output logic [3:0] ovl_ry,
    output logic [3:0] ovl_by
);
    logic [PIX_W-1:0]  pix_cnt;
    logic [LINE_W-1:0] line_cnt;
    logic              field_start;
    inset_cfg_t        cfg_in, cfg_sh;
    rect_t             vis_rect, frame_rect;
    inset_out_t        res;

    always_comb begin
        cfg_in.hpos      = hpos;
        cfg_in.vpos      = vpos;
        cfg_in.hrange    = hrange;
        cfg_in.vrange    = vrange;
        cfg_in.edge_en   = edge_en;
        cfg_in.wipe_mode = wipe_mode;
        cfg_in.mask_en   = mask_en;
        cfg_in.disp_on   = disp_on;
        cfg_in.color_en  = color_en;
        cfg_in.col_y     = col_y;
        cfg_in.col_ry    = col_ry;
        cfg_in.col_by    = col_by;
    end

    inset_sync_counter #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_cnt (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .pix(pix_cnt), .line(line_cnt), .field_start(field_start)
    );

    inset_cfg_shadow u_shadow (
        .clk(clk), .rst(rst), .load(field_start),
        .cfg_in(cfg_in), .cfg_q(cfg_sh)
    );

    inset_geometry #(.INSET_W(INSET_W), .INSET_H(INSET_H)) u_geom (
        .hpos(cfg_sh.hpos), .vpos(cfg_sh.vpos),
        .hrange(cfg_sh.hrange), .vrange(cfg_sh.vrange),
        .edge_en(cfg_sh.edge_en), .wipe_mode(cfg_sh.wipe_mode),
        .mask_en(cfg_sh.mask_en),
        .vis_rect(vis_rect), .frame_rect(frame_rect)
    );

    inset_classify #(
        .PIX_W(PIX_W), .LINE_W(LINE_W),
        .BORDER_PX(BORDER_PX), .BORDER_LN(BORDER_LN)
    ) u_cls (
        .pix(pix_cnt), .line(line_cnt),
        .vis_rect(vis_rect), .frame_rect(frame_rect),
        .disp_on(cfg_sh.disp_on), .color_en(cfg_sh.color_en),
        .col_y(cfg_sh.col_y), .col_ry(cfg_sh.col_ry), .col_by(cfg_sh.col_by),
        .res(res)
    );

    assign inset_active = res.active;
    assign border_pin   = res.pin;
    assign border_ovl   = res.ovl;
    assign ovl_y        = res.y;
    assign ovl_ry       = res.ry;
    assign ovl_by       = res.by;
endmodule

// File: rtl/inset_window_gen_chk.sv
module inset_window_gen_chk
    import inset_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              hsync_n,
    input logic              vsync_n,
    input logic [PIX_W-1:0]  pix_cnt,
    input logic [LINE_W-1:0] line_cnt,
    input inset_cfg_t        cfg_sh,
    input logic              inset_active,
    input logic              border_pin,
    input logic              border_ovl,
    input logic [3:0]        ovl_y,
    input logic [3:0]        ovl_ry,
    input logic [3:0]        ovl_by
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!inset_active && !border_pin && !border_ovl));

    a_r2_pix_restart: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |=> (pix_cnt == '0));

    a_r2_line_restart: assert property (@(posedge clk) disable iff (rst)
        $fell(vsync_n) |=> (line_cnt == '0));

    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !$fell(vsync_n) |=> $stable(cfg_sh));

    a_r9_pin_vs_active: assert property (@(posedge clk) disable iff (rst)
        !(border_pin && inset_active));

    a_r10_ovl_needs_pin: assert property (@(posedge clk) disable iff (rst)
        border_ovl |-> border_pin);

    a_r10_colour_idle: assert property (@(posedge clk) disable iff (rst)
        !border_ovl |-> (ovl_y == 4'd0 && ovl_ry == 4'd0 && ovl_by == 4'd0));
endmodule

bind inset_window_gen inset_window_gen_chk #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .cfg_sh(cfg_sh),
    .inset_active(inset_active), .border_pin(border_pin), .border_ovl(border_ovl),
    .ovl_y(ovl_y), .ovl_ry(ovl_ry), .ovl_by(ovl_by)
);

// File: tb/inset_window_gen_test.sv
module inset_window_gen_test;
    import inset_pkg::*;

    localparam int W      = 12;
    localparam int H      = 6;
    localparam int LLEN   = 30;
    localparam int NLINES = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hsync_n = 1'b1;
    logic vsync_n = 1'b1;
    inset_cfg_t drv = '0;

    logic       inset_active, border_pin, border_ovl;
    logic [3:0] ovl_y, ovl_ry, ovl_by;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    inset_window_gen #(.INSET_W(W), .INSET_H(H)) uut (
        .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .hpos(drv.hpos), .vpos(drv.vpos), .hrange(drv.hrange), .vrange(drv.vrange),
        .edge_en(drv.edge_en), .wipe_mode(drv.wipe_mode), .mask_en(drv.mask_en),
        .disp_on(drv.disp_on), .color_en(drv.color_en),
        .col_y(drv.col_y), .col_ry(drv.col_ry), .col_by(drv.col_by),
        .inset_active(inset_active), .border_pin(border_pin), .border_ovl(border_ovl),
        .ovl_y(ovl_y), .ovl_ry(ovl_ry), .ovl_by(ovl_by)
    );

    function automatic logic [14:0] expect_at(inset_cfg_t c, int x, int y);
        int lc, rc, tc, bc, l0, r0, t0, b0, fl, fr, ft, fb;
        bit ok, act, fok, outer, inner, pin, ovl;
        l0 = c.hpos; r0 = l0 + W; t0 = c.vpos; b0 = t0 + H;
        lc = (c.mask_en && c.edge_en[1]) ? int'(c.hrange) : 0;
        rc = (c.mask_en && c.edge_en[0]) ? int'(c.hrange) : 0;
        tc = (c.mask_en && c.edge_en[3]) ? int'(c.vrange) : 0;
        bc = (c.mask_en && c.edge_en[2]) ? int'(c.vrange) : 0;
        ok  = (lc + rc < W) && (tc + bc < H);
        act = c.disp_on && ok && x >= l0 + lc && x < r0 - rc && y >= t0 + tc && y < b0 - bc;
        if (c.mask_en && c.wipe_mode) begin
            fl = l0 + lc; fr = r0 - rc; ft = t0 + tc; fb = b0 - bc; fok = ok;
        end else begin
            fl = l0; fr = r0; ft = t0; fb = b0; fok = 1'b1;
        end
        outer = x >= fl - 2 && x < fr + 2 && y >= ft - 1 && y < fb + 1;
        inner = x >= fl && x < fr && y >= ft && y < fb;
        pin = c.disp_on && fok && outer && !inner;
        ovl = pin && c.color_en;
        return {act, pin, ovl, ovl ? c.col_y : 4'd0, ovl ? c.col_ry : 4'd0, ovl ? c.col_by : 4'd0};
    endfunction

    task automatic check_now(string req, logic [14:0] exp_v, int x, int y);
        logic [14:0] got;
        got = {inset_active, border_pin, border_ovl, ovl_y, ovl_ry, ovl_by};
        checks++;
        if (got !== exp_v) begin
            failures++;
            $display("FAIL %s x=%0d y=%0d actual=%h expected=%h", req, x, y, got, exp_v);
        end
    endtask

    // Settings are inverted after line 0: the field must still use c (R5).
    task automatic run_field(inset_cfg_t c, string req);
        for (int l = 0; l < NLINES; l++) begin
            for (int j = 0; j < LLEN; j++) begin
                @(negedge clk);
                hsync_n = (j < 2) ? 1'b0 : 1'b1;
                vsync_n = (l == 0 && j < 2) ? 1'b0 : 1'b1;
                drv = (l == 0) ? c : ~c;
                @(posedge clk);
                #1;
                check_now(req, expect_at(c, j, l), j, l);
            end
        end
    endtask

    function automatic inset_cfg_t mk(int hp, int vp, int hr, int vr, int edges,
                                      bit wipe, bit mask, bit disp, bit col);
        inset_cfg_t c;
        c.hpos = 8'(hp); c.vpos = 8'(vp); c.hrange = 6'(hr); c.vrange = 6'(vr);
        c.edge_en = 4'(edges); c.wipe_mode = wipe; c.mask_en = mask;
        c.disp_on = disp; c.color_en = col;
        c.col_y = 4'hA; c.col_ry = 4'h5; c.col_by = 4'h3;
        return c;
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            report();
            $finish;
        end
    end

    initial begin
        inset_cfg_t c;
        drv = mk(10, 3, 0, 0, 0, 0, 0, 1, 1);
        repeat (3) @(posedge clk);
        #1;
        check_now("R1 in reset", 15'd0, -1, -1);
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            #1;
            check_now("R1 before first vsync", 15'd0, k, -1);
        end

        run_field(mk(10, 3, 0, 0, 0, 0, 0, 1, 0), "R2 R3 plain window");
        run_field(mk(10, 3, 3, 2, 15, 1, 0, 1, 1), "R8 mask off ignores edges");
        run_field(mk(10, 3, 3, 1, 4'b1010, 1, 1, 1, 0), "R6 wipe top left");
        run_field(mk(9, 2, 2, 2, 4'b0101, 1, 1, 1, 1), "R6 wipe bottom right");
        run_field(mk(10, 3, 2, 1, 15, 0, 1, 1, 1), "R7 area all edges");
        run_field(mk(10, 3, 6, 1, 4'b0011, 1, 1, 1, 1), "R11 wipe collapse");
        run_field(mk(10, 3, 6, 1, 4'b0011, 0, 1, 1, 1), "R11 area collapse");
        run_field(mk(10, 3, 2, 1, 15, 1, 1, 0, 1), "R4 display off");
        run_field(mk(0, 0, 0, 0, 0, 0, 0, 1, 1), "R9 R10 origin border");
        c = mk(14, 4, 0, 0, 0, 0, 0, 1, 1);
        c.col_y = 4'hF; c.col_ry = 4'h1; c.col_by = 4'hC;
        run_field(c, "R10 colour values");
        run_field(mk(5, 1, 1, 1, 4'b1000, 1, 1, 1, 0), "R5 shadow after change");

        finished = 1'b1;
        report();
        $finish;
    end
endmodule